// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

A fully associative translation buffer, managed by software, that turns virtual addresses into physical addresses. Every slot holds a virtual page, a physical page, a valid bit and its own page size. The four sizes are 8 KB, 64 KB, 512 KB and 4 MB, and slots of different sizes sit side by side. On a lookup every valid slot is compared at once. Each slot ignores the address bits that fall inside its own page. The physical address comes out in the same cycle as the request, with no register on the way.

A lookup that matches no slot raises a miss flag. Software then programs the missing translation through the write port. The write goes to a slot that software names, or to the lowest free slot, or, when every slot is full, to the slot that a rotating victim pointer selects. Software removes translations with a single-slot invalidate or an invalidate-all. Two wrapping counters record hits and misses, so that software can judge how much of the working set the buffer covers.

Top module: `mpsz_tlb`

## Requirements
- R1: The buffer holds 64 translations. All valid slots are compared in parallel on every lookup, and all 64 can be valid at the same time.
- R2: Page size code `wr_size`: 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB. The code sets how many low address bits (13, 16, 19 or 22) each slot leaves out of its compare. The physical address takes those low bits from the lookup address and its upper bits from the slot's physical page.
- R3: When `wr_size_vld` is 0 the written slot gets the 8 KB size, whatever `wr_size` holds.
- R4: On a hit, `lk_paddr` is valid in the same cycle as `lk_valid`. It reflects the table as it stood before any write at that clock edge.
- R5: `lk_miss` is 1 exactly when `lk_valid` is 1 and no valid slot matches. `lk_paddr` is then 0. With `lk_valid` at 0, `lk_hit`, `lk_miss` and `lk_multi` are all 0.
- R6: A write with `wr_use_idx` = 0 goes to the lowest-index invalid slot, judged on the valid bits before that edge.
- R7: A write with `wr_use_idx` = 0 while every slot is valid replaces the slot named by a victim pointer. That pointer starts at 0 on reset and steps by one, wrapping from 63 to 0, on every write with `wr_use_idx` = 0 that is not blocked by `inv_all`.
- R8: A write with `wr_use_idx` = 1 replaces slot `wr_idx`, whether or not that slot is valid, and leaves the victim pointer unchanged.
- R9: When two or more valid slots match, `lk_multi` and `lk_hit` are 1 and the lowest-index match supplies the physical address.
- R10: `inv_all` clears every valid bit at the next edge. A write in the same cycle is dropped and does not move the victim pointer.
- R11: `inv_one` clears slot `inv_idx` at the next edge. A write to that same slot in the same cycle wins, and the slot holds the new translation.
- R12: `hit_count` and `miss_count` reset to 0 and rise by one at each edge where `lk_hit` or `lk_miss` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup matched at least one slot |
| lk_miss | output | 1 | Miss exception |
| lk_multi | output | 1 | More than one slot matched |
| lk_paddr | output | 32 | Translated physical address |
| wr_en | input | 1 | Program a translation |
| wr_use_idx | input | 1 | Use `wr_idx` as the target slot |
| wr_idx | input | 6 | Explicit target slot |
| wr_vpn | input | 19 | Virtual page, address bits 31:13 |
| wr_ppn | input | 19 | Physical page, address bits 31:13 |
| wr_size_vld | input | 1 | `wr_size` is meaningful |
| wr_size | input | 2 | Page size code |
| inv_one | input | 1 | Invalidate one slot |
| inv_idx | input | 6 | Slot to invalidate |
| inv_all | input | 1 | Invalidate every slot |
| hit_count | output | 32 | Lookups that hit |
| miss_count | output | 32 | Lookups that missed |

## Verification
The bench targets the page-size boundaries: an address one byte past a large page, and a small page lying inside a large one. A design with the wrong mask width would hit there or miss there, or would give back a physical address with a mixed-up middle field. It also fills all 64 slots and writes past them, so that a victim pointer that stalls, skips or moves on explicit writes evicts the wrong page and a later lookup disagrees. Same-cycle collisions are driven on purpose: a lookup during a write to the same address, a write and an invalidate aimed at one slot, and a write during an invalidate-all. A wrong priority in any of these leaves a translation present that should be gone, or gone that should be present.

// File: rtl/mpsz_tlb.sv
module mpsz_tlb #(
  parameter int N_ENT   = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int CNT_W   = 32,
  parameter int PG_SH   = 13,
  parameter int SZ_STEP = 3,
  parameter int IDX_W   = $clog2(N_ENT),
  parameter int VPN_W   = VA_W - PG_SH,
  parameter int PPN_W   = PA_W - PG_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_multi,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             wr_en,
  input  logic             wr_use_idx,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_size_vld,
  input  logic [1:0]       wr_size,
  input  logic             inv_one,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             inv_all,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);

  logic [N_ENT-1:0] vld;
  logic [VPN_W-1:0] e_vpn [N_ENT];
  logic [PPN_W-1:0] e_ppn [N_ENT];
  logic [1:0]       e_sz  [N_ENT];
  logic [IDX_W-1:0] rr_ptr, hit_idx, free_idx, wslot;
  logic [N_ENT-1:0] hv;
  logic             any_free;
  logic [PPN_W-1:0] pm, sel_ppn;
  logic [1:0]       wsz;
  logic [VPN_W-1:0] l_vpn;

  function automatic logic [VPN_W-1:0] vmask(input logic [1:0] s);
    vmask = {VPN_W{1'b1}} << (SZ_STEP * int'(s));
  endfunction

  function automatic logic [PPN_W-1:0] pmask(input logic [1:0] s);
    pmask = {PPN_W{1'b1}} << (SZ_STEP * int'(s));
  endfunction

  assign l_vpn = lk_vaddr[VA_W-1:PG_SH];

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hv[g] = vld[g] && (((e_vpn[g] ^ l_vpn) & vmask(e_sz[g])) == '0);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (hv[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!vld[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  assign pm       = pmask(e_sz[hit_idx]);
  assign sel_ppn  = (e_ppn[hit_idx] & pm) | (PPN_W'(l_vpn) & ~pm);
  assign lk_hit   = lk_valid && (|hv);
  assign lk_miss  = lk_valid && !(|hv);
  assign lk_multi = lk_valid && ((hv & (hv - N_ENT'(1))) != '0);
  assign lk_paddr = lk_hit ? {sel_ppn, lk_vaddr[PG_SH-1:0]} : '0;

  assign wslot = wr_use_idx ? wr_idx : (any_free ? free_idx : rr_ptr);
  assign wsz   = wr_size_vld ? wr_size : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (inv_all) begin
      vld <= '0;
    end else begin
      if (inv_one) vld[inv_idx] <= 1'b0;
      if (wr_en)   vld[wslot]   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) begin
      e_vpn[wslot] <= wr_vpn;
      e_ppn[wslot] <= wr_ppn;
      e_sz[wslot]  <= wsz;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr     <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (wr_en && !wr_use_idx && !inv_all)
        rr_ptr <= (rr_ptr == IDX_W'(N_ENT - 1)) ? '0 : rr_ptr + 1'b1;
      if (lk_hit)  hit_count  <= hit_count + 1'b1;
      if (lk_miss) miss_count <= miss_count + 1'b1;
    end
  end

endmodule

// File: rtl/mpsz_tlb_chk.sv
module mpsz_tlb_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int CNT_W = 32,
  parameter int PG_SH = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_multi,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             inv_all,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);

  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss && !lk_multi));

  a_r5_miss_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_paddr == '0));

  a_r9_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  a_r2_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[PG_SH-1:0] == lk_vaddr[PG_SH-1:0]));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

  a_r12_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> (hit_count == $past(hit_count) + CNT_W'(1)));

  a_r12_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |=> $stable(hit_count));

  a_r12_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> (miss_count == $past(miss_count) + CNT_W'(1)));

  a_r12_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_miss |=> $stable(miss_count));

endmodule

bind mpsz_tlb mpsz_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .CNT_W(CNT_W), .PG_SH(PG_SH)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_paddr(lk_paddr),
  .inv_all(inv_all), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/tb_mpsz_tlb.sv
module tb_mpsz_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, lk_multi;
  logic [31:0] lk_paddr;
  logic        wr_en = 1'b0, wr_use_idx = 1'b0, wr_size_vld = 1'b0;
  logic [5:0]  wr_idx = '0, inv_idx = '0;
  logic [18:0] wr_vpn = '0, wr_ppn = '0;
  logic [1:0]  wr_size = '0;
  logic        inv_one = 1'b0, inv_all = 1'b0;
  logic [31:0] hit_count, miss_count;

  always #5 clk = ~clk;

  mpsz_tlb dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_paddr(lk_paddr),
    .wr_en(wr_en), .wr_use_idx(wr_use_idx), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_ppn(wr_ppn), .wr_size_vld(wr_size_vld), .wr_size(wr_size),
    .inv_one(inv_one), .inv_idx(inv_idx), .inv_all(inv_all),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R5";
  bit done = 0;

  bit          mv [64];
  int unsigned m_va [64], m_pa [64];
  int          m_sz [64];
  int          rr = 0;
  int unsigned m_hits = 0, m_miss = 0;

  task automatic chk(input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, nm, act, exp);
    end
  endtask

  function automatic void mlook(input int unsigned va, output bit h, output bit mh,
                                output int unsigned pa);
    h = 0; mh = 0; pa = 0;
    for (int i = 0; i < 64; i++) begin
      if (mv[i]) begin
        int sh;
        sh = 13 + 3 * m_sz[i];
        if ((va >> sh) == (m_va[i] >> sh)) begin
          if (!h) begin
            h = 1;
            pa = ((m_pa[i] >> sh) << sh) | (va & ((32'h1 << sh) - 1));
          end else mh = 1;
        end
      end
    end
  endfunction

  task automatic tick();
    bit h, mh;
    int unsigned pa;
    int slot;
    #1;
    h = 0; mh = 0; pa = 0;
    if (lk_valid) mlook(lk_vaddr, h, mh, pa);
    chk("hit", 32'(lk_hit), 32'(h));
    chk("miss", 32'(lk_miss), 32'(lk_valid && !h));
    chk("multi", 32'(lk_multi), 32'(mh));
    chk("paddr", lk_paddr, pa);
    @(posedge clk);
    if (lk_valid && h) m_hits++;
    if (lk_valid && !h) m_miss++;
    if (inv_all) begin
      for (int i = 0; i < 64; i++) mv[i] = 0;
    end else begin
      slot = -1;
      if (wr_en) begin
        if (wr_use_idx) slot = wr_idx;
        else begin
          for (int i = 63; i >= 0; i--) if (!mv[i]) slot = i;
          if (slot < 0) slot = rr;
          rr = (rr + 1) % 64;
        end
      end
      if (inv_one) mv[inv_idx] = 0;
      if (slot >= 0) begin
        mv[slot] = 1;
        m_va[slot] = {wr_vpn, 13'b0};
        m_pa[slot] = {wr_ppn, 13'b0};
        m_sz[slot] = wr_size_vld ? int'(wr_size) : 0;
      end
    end
    #1;
    chk("hit_count", hit_count, m_hits);
    chk("miss_count", miss_count, m_miss);
    @(negedge clk);
  endtask

  task automatic look(input int unsigned va);
    lk_valid = 1; lk_vaddr = va;
    tick();
    lk_valid = 0;
  endtask

  task automatic wr(input bit ui, input int idx, input int unsigned va, input int unsigned pa,
                    input bit sv, input int sz);
    wr_en = 1; wr_use_idx = ui; wr_idx = 6'(idx); wr_vpn = va[31:13]; wr_ppn = pa[31:13];
    wr_size_vld = sv; wr_size = 2'(sz);
    tick();
    wr_en = 0;
  endtask

  task automatic inv1(input int idx);
    inv_one = 1; inv_idx = 6'(idx);
    tick();
    inv_one = 0;
  endtask

  task automatic flush();
    inv_all = 1;
    tick();
    inv_all = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R5";
    look(32'h0000_2000);
    look(32'hFFFF_FFFF);
    tick();

    cur_req = "R3";
    wr(0, 0, 32'h0001_2000, 32'h0ABC_0000, 0, 3);
    look(32'h0001_2345);
    look(32'h0001_4000);
    look(32'h0001_1FFF);

    cur_req = "R2";
    wr(0, 0, 32'h1000_0000, 32'h2000_0000, 1, 1);
    wr(0, 0, 32'h2008_0000, 32'h5010_0000, 1, 2);
    wr(0, 0, 32'h3040_0000, 32'h7FC0_0000, 1, 3);
    look(32'h1000_ABCD); look(32'h1001_0000); look(32'h1000_FFFF);
    look(32'h200F_FFF0); look(32'h2010_0000); look(32'h2007_FFFF);
    look(32'h307F_FFFF); look(32'h3080_0000); look(32'h3045_6789);

    cur_req = "R4";
    lk_valid = 1; lk_vaddr = 32'h0002_0010;
    wr_en = 1; wr_use_idx = 1; wr_idx = 6'd9; wr_vpn = 19'h10; wr_ppn = 19'h77; wr_size_vld = 0;
    tick();
    wr_en = 0;
    tick();
    lk_valid = 0;

    cur_req = "R6";
    inv1(1);
    wr(0, 0, 32'h0060_0000, 32'h0066_0000, 0, 0);
    look(32'h0060_0123);
    wr(1, 1, 32'h0070_0000, 32'h0077_0000, 0, 0);
    look(32'h0060_0123);
    look(32'h0070_0123);

    cur_req = "R1";
    flush();
    for (int i = 0; i < 64; i++) wr(0, 0, 32'h4000_0000 + i * 32'h2000, 32'h8000_0000 + i * 32'h6000, 0, 0);
    for (int i = 0; i < 64; i++) look(32'h4000_0000 + i * 32'h2000 + 32'(i));

    cur_req = "R7";
    for (int i = 0; i < 5; i++) wr(0, 0, 32'h5000_0000 + i * 32'h2000, 32'h9000_0000 + i * 32'h2000, 0, 0);
    for (int i = 0; i < 64; i++) look(32'h4000_0000 + i * 32'h2000);
    for (int i = 0; i < 5; i++) look(32'h5000_0000 + i * 32'h2000 + 32'h10);

    cur_req = "R8";
    wr(1, 40, 32'h6000_0000, 32'h6100_0000, 1, 1);
    look(32'h6000_F000);
    look(32'h4000_0000 + 40 * 32'h2000);
    wr(0, 0, 32'h5100_0000, 32'h9100_0000, 0, 0);
    look(32'h5100_0000);

    cur_req = "R9";
    flush();
    wr(1, 10, 32'h0040_0000, 32'h0C00_0000, 1, 3);
    wr(1, 3, 32'h0041_2000, 32'h0000_6000, 0, 0);
    look(32'h0041_2ABC);
    look(32'h0050_0000);
    wr(1, 2, 32'h0041_0000, 32'h0123_0000, 1, 1);
    look(32'h0041_2ABC);

    cur_req = "R11";
    inv1(2);
    look(32'h0041_2ABC);
    inv1(10);
    look(32'h0050_0000);
    inv_one = 1; inv_idx = 6'd3;
    wr(1, 3, 32'h0090_0000, 32'h0099_0000, 0, 0);
    inv_one = 0;
    look(32'h0090_0042);

    cur_req = "R10";
    inv_all = 1;
    wr(0, 0, 32'h00A0_0000, 32'h00AA_0000, 0, 0);
    inv_all = 0;
    look(32'h0090_0042);
    look(32'h00A0_0000);
    wr(0, 0, 32'h00B0_0000, 32'h00BB_0000, 0, 0);
    look(32'h00B0_0000);

    cur_req = "R12";
    for (int k = 0; k < 3000; k++) begin
      int op;
      op = int'($urandom % 8);
      lk_valid = (op < 5);
      lk_vaddr = 32'h0040_0000 | ($urandom & 32'h003F_FFFF);
      wr_en = (op >= 4) && (op != 7);
      wr_use_idx = $urandom % 3 == 0;
      wr_idx = 6'($urandom);
      wr_vpn = 19'(32'h0200 | ($urandom & 32'h01FF));
      wr_ppn = 19'($urandom);
      wr_size_vld = $urandom % 4 != 0;
      wr_size = 2'($urandom);
      inv_one = (op == 7);
      inv_idx = 6'($urandom);
      inv_all = ($urandom % 200) == 0;
      tick();
    end
    lk_valid = 0; wr_en = 0; inv_one = 0; inv_all = 0;
    tick();

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule